// File: doc/BRIEF.md
# Double-Rate Ring Capture Recorder

This block records a wide stream of link samples into a single 36-bit memory that it uses as a ring buffer. Each input sample carries eight 8-bit channels, and each channel has a 1-bit control flag, so a sample holds 72 bits. That is twice the memory word width. The block therefore runs its memory port at twice the sample rate. Every accepted sample becomes two consecutive memory words, and the two words of a sample are called a pair. The write pointer moves forward one word per write and wraps around the memory without pausing. Capture continues until a stop request arrives.

A stop request never splits a pair. If a stop arrives while a pair is open, the block finishes writing the odd word and only then freezes. On freeze it takes a snapshot of the write pointer and of a flag that shows whether the ring has wrapped. A host then reads the captured history through a plain address/data read port. If the wrapped flag is set, the oldest entry sits at the snapshot pointer; if it is clear, the oldest entry is at address 0. A restart request releases the freeze, clears the pointer and the wrapped flag, and starts capture again.

The block clocks on the memory-rate clock. `sampleValid` marks a new sample, and samples may arrive at most once every two clocks.

Top module: `ring_capture_recorder`

## Requirements
- R1: After reset, `frozen`, `hostRdValid`, `frzWrap` and `frzPtr` are all 0, and the write pointer is at address 0.
- R2: An accepted sample is written as an even word at the current pointer and then an odd word at pointer+1 on the next clock. Both words use the same layout: channel k occupies bits 8k+7:8k and its control flag sits at bit 32+k. The even word carries channels 0 to 3 with their flags. The odd word carries channels 4 to 7 with their flags.
- R3: An assertion of `sampleValid` in the clock where the odd word is being written is ignored. Nothing from that sample is stored.
- R4: The pointer wraps from the last address to 0, and capture continues by overwriting the oldest words. The wrapped flag becomes 1 at the first wrap and stays 1 until restart.
- R5: A stop request in a clock with no open pair and no new sample freezes the block at that clock edge. A stop request in the clock of an odd-word write freezes the block right after that write.
- R6: If a stop request and an accepted sample fall in the same clock, both words of that sample are written and `frozen` rises one clock later.
- R7: At freeze, `frzPtr` takes the address after the last written word and `frzWrap` takes the wrapped flag. While frozen, nothing is written to memory and the snapshot does not change.
- R8: A host read (`hostRdEn`) while frozen returns the word at `hostAddr` on `hostRdData`, with `hostRdValid` high one clock later. A host read while capturing is ignored: `hostRdValid` stays 0.
- R9: A restart while frozen clears `frozen`, the pointer, the wrapped flag and the snapshot, and capture starts again from address 0. A restart while capturing is ignored, and the pointer keeps counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory-rate clock (twice the sample rate) |
| rstN | input | 1 | Active-low synchronous reset |
| sampleValid | input | 1 | New sample on chData/chCtl |
| chData | input | 64 | Eight channels; channel k at bits 8k+7:8k |
| chCtl | input | 8 | Control flag per channel; bit k belongs to channel k |
| stopReq | input | 1 | Request to freeze capture |
| restartReq | input | 1 | Request to resume capture from address 0 |
| hostRdEn | input | 1 | Host read strobe |
| hostAddr | input | 6 | Host read word address |
| hostRdData | output | 36 | Word read from memory |
| hostRdValid | output | 1 | hostRdData holds the result of an accepted read |
| frozen | output | 1 | Capture is stopped |
| frzPtr | output | 6 | Write pointer snapshot taken at freeze |
| frzWrap | output | 1 | Wrapped-flag snapshot taken at freeze |

## Verification
Two functions can meet in one clock: a stop request can land in the same clock as the acceptance of a new sample. The bench provokes this by raising `stopReq` and `sampleValid` together. It then checks that `frozen` is still low one clock later and high the clock after that. It also checks that the snapshot pointer has advanced by two words and that both words read back with the sample's contents. A second meeting point is a sample offered during an odd-word write. The bench judges that case by the pointer advancing only two words and by the stored pair holding the first sample.

// File: rtl/ring_capture_pkg.sv
package ring_capture_pkg;

  // Strobes from the control FSM to the datapath
  typedef struct packed {
    logic wrEven;    // write the low half of the sample this clock
    logic wrOdd;     // write the held high half this clock
    logic ptrClear;  // restart: clear pointer, wrap flag and snapshot
    logic snapshot;  // freeze: latch pointer and wrap flag
    logic rdEnable;  // accepted host read
  } rec_strobe_t;

endpackage

// File: rtl/ring_capture_ctrl.sv
module ring_capture_ctrl
  import ring_capture_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        sampleValid,
  input  logic        stopReq,
  input  logic        restartReq,
  input  logic        hostRdEn,
  output rec_strobe_t strobe,
  output logic        frozen
);

  logic phaseOdd;     // an odd word is owed this clock
  logic stopPending;  // stop seen while a pair was opening
  logic stopSeen;
  logic freezeNow;

  assign stopSeen  = stopReq | stopPending;
  // Freeze only when no pair stays open after this clock
  assign freezeNow = !frozen && stopSeen && (phaseOdd || !sampleValid);

  always_comb begin
    strobe          = '0;
    strobe.wrEven   = !frozen && !phaseOdd && sampleValid;
    strobe.wrOdd    = !frozen && phaseOdd;
    strobe.snapshot = freezeNow;
    strobe.ptrClear = frozen && restartReq;
    strobe.rdEnable = frozen && hostRdEn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      frozen      <= 1'b0;
      phaseOdd    <= 1'b0;
      stopPending <= 1'b0;
    end else begin
      phaseOdd    <= strobe.wrEven;
      stopPending <= !frozen && stopSeen && !freezeNow;
      if (strobe.ptrClear)
        frozen <= 1'b0;
      else if (freezeNow)
        frozen <= 1'b1;
    end
  end

  // R2: every even write is followed by its odd write
  p_pair_complete_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEven |=> strobe.wrOdd);

  // R7: no memory writes while frozen
  p_no_write_frozen_r7: assert property (@(posedge clk) disable iff (!rstN)
    frozen |-> !(strobe.wrEven || strobe.wrOdd));

  // R5: freeze never lands between the two halves of a pair
  p_no_split_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(frozen) |-> !$past(strobe.wrEven));

  // R3: a sample offered during an odd write starts no new pair
  p_ignore_busy_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrOdd |-> !strobe.wrEven);

endmodule

// File: rtl/ring_capture_datapath.sv
module ring_capture_datapath
  import ring_capture_pkg::*;
#(
  parameter int CH_NUM = 8,
  parameter int CH_W   = 8,
  parameter int ADDR_W = 6,
  localparam int HALF_CH = CH_NUM / 2,
  localparam int WORD_W  = HALF_CH * (CH_W + 1),
  localparam int DEPTH   = 1 << ADDR_W
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  rec_strobe_t            strobe,
  input  logic [CH_NUM*CH_W-1:0] chData,
  input  logic [CH_NUM-1:0]      chCtl,
  input  logic [ADDR_W-1:0]      hostAddr,
  output logic [WORD_W-1:0]      hostRdData,
  output logic                   hostRdValid,
  output logic [ADDR_W-1:0]      frzPtr,
  output logic                   frzWrap
);

  logic [WORD_W-1:0]       mem [DEPTH];
  logic [HALF_CH*CH_W-1:0] holdData;
  logic [HALF_CH-1:0]      holdCtl;
  logic [ADDR_W-1:0]       wrPtr, ptrNext;
  logic                    wrapped, wrapNext;
  logic                    ptrInc;
  logic [WORD_W-1:0]       evenWord, oddWord, wrWord;

  // Word packing: channel k of a half at bits k*CH_W, its flag above the data
  for (genvar g = 0; g < HALF_CH; g++) begin : g_pack
    assign evenWord[g*CH_W +: CH_W]  = chData[g*CH_W +: CH_W];
    assign oddWord[g*CH_W +: CH_W]   = holdData[g*CH_W +: CH_W];
    assign evenWord[HALF_CH*CH_W + g] = chCtl[g];
    assign oddWord[HALF_CH*CH_W + g]  = holdCtl[g];
  end

  assign wrWord = strobe.wrOdd ? oddWord : evenWord;
  assign ptrInc = strobe.wrEven | strobe.wrOdd;

  always_comb begin
    ptrNext  = wrPtr;
    wrapNext = wrapped;
    if (strobe.ptrClear) begin
      ptrNext  = '0;
      wrapNext = 1'b0;
    end else if (ptrInc) begin
      ptrNext = wrPtr + ADDR_W'(1);
      if (wrPtr == ADDR_W'(DEPTH - 1))
        wrapNext = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr       <= '0;
      wrapped     <= 1'b0;
      frzPtr      <= '0;
      frzWrap     <= 1'b0;
      hostRdValid <= 1'b0;
      holdData    <= '0;
      holdCtl     <= '0;
    end else begin
      wrPtr       <= ptrNext;
      wrapped     <= wrapNext;
      hostRdValid <= strobe.rdEnable;
      if (strobe.wrEven) begin
        holdData <= chData[CH_NUM*CH_W-1 -: HALF_CH*CH_W];
        holdCtl  <= chCtl[CH_NUM-1 -: HALF_CH];
      end
      if (strobe.ptrClear) begin
        frzPtr  <= '0;
        frzWrap <= 1'b0;
      end else if (strobe.snapshot) begin
        frzPtr  <= ptrNext;
        frzWrap <= wrapNext;
      end
    end
  end

  // Inferred single-write, single-read memory
  always_ff @(posedge clk) begin
    if (ptrInc)
      mem[wrPtr] <= wrWord;
    if (strobe.rdEnable)
      hostRdData <= mem[hostAddr];
  end

  // R2: each written word advances the pointer by exactly one
  p_ptr_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    (ptrInc && !strobe.ptrClear) |=> wrPtr == $past(wrPtr) + ADDR_W'(1));

  // R2: even words always land on even addresses
  p_even_addr_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrEven |-> !wrPtr[0]);

  // R4: wrapped flag is sticky until restart
  p_wrap_sticky_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wrapped && !strobe.ptrClear) |=> wrapped);

  // R9: restart leaves pointer at zero
  p_restart_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.ptrClear |=> (wrPtr == '0 && !wrapped));

endmodule

// File: rtl/ring_capture_recorder.sv
module ring_capture_recorder
  import ring_capture_pkg::*;
#(
  parameter int CH_NUM = 8,
  parameter int CH_W   = 8,
  parameter int ADDR_W = 6,
  localparam int WORD_W = (CH_NUM / 2) * (CH_W + 1)
)(
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   sampleValid,
  input  logic [CH_NUM*CH_W-1:0] chData,
  input  logic [CH_NUM-1:0]      chCtl,
  input  logic                   stopReq,
  input  logic                   restartReq,
  input  logic                   hostRdEn,
  input  logic [ADDR_W-1:0]      hostAddr,
  output logic [WORD_W-1:0]      hostRdData,
  output logic                   hostRdValid,
  output logic                   frozen,
  output logic [ADDR_W-1:0]      frzPtr,
  output logic                   frzWrap
);

  rec_strobe_t strobe;

  ring_capture_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .sampleValid (sampleValid),
    .stopReq     (stopReq),
    .restartReq  (restartReq),
    .hostRdEn    (hostRdEn),
    .strobe      (strobe),
    .frozen      (frozen)
  );

  ring_capture_datapath #(
    .CH_NUM (CH_NUM),
    .CH_W   (CH_W),
    .ADDR_W (ADDR_W)
  ) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .chData      (chData),
    .chCtl       (chCtl),
    .hostAddr    (hostAddr),
    .hostRdData  (hostRdData),
    .hostRdValid (hostRdValid),
    .frzPtr      (frzPtr),
    .frzWrap     (frzWrap)
  );

  // R8: read data is valid only for reads issued while frozen
  p_read_frozen_r8: assert property (@(posedge clk) disable iff (!rstN)
    hostRdValid |-> $past(frozen));

  // R7: snapshot is stable while frozen unless restarted
  p_snap_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    (frozen && $past(frozen) && !$past(restartReq)) |-> $stable(frzPtr));

endmodule

// File: tb/ring_capture_recorder_tb_top.sv
module ring_capture_recorder_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleValid;
  logic [63:0] chData;
  logic [7:0]  chCtl;
  logic        stopReq, restartReq, hostRdEn;
  logic [5:0]  hostAddr;
  logic [35:0] hostRdData;
  logic        hostRdValid, frozen, frzWrap;
  logic [5:0]  frzPtr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  logic [35:0] expMem [64];
  int          expPtr;
  bit          expWrap;

  always #2 clk = ~clk;

  ring_capture_recorder dut_i (
    .clk(clk), .rstN(rstN), .sampleValid(sampleValid), .chData(chData),
    .chCtl(chCtl), .stopReq(stopReq), .restartReq(restartReq),
    .hostRdEn(hostRdEn), .hostAddr(hostAddr), .hostRdData(hostRdData),
    .hostRdValid(hostRdValid), .frozen(frozen), .frzPtr(frzPtr),
    .frzWrap(frzWrap)
  );

  task automatic check(string tag, logic [35:0] got, logic [35:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h exp %h", tag, got, exp);
    end
  endtask

  task automatic modelWrite(logic [35:0] w);
    expMem[expPtr] = w;
    if (expPtr == 63) expWrap = 1;
    expPtr = (expPtr + 1) % 64;
  endtask

  task automatic sendSample(logic [63:0] d, logic [7:0] c);
    @(negedge clk); sampleValid = 1; chData = d; chCtl = c;
    @(negedge clk); sampleValid = 0;
    modelWrite({c[3:0], d[31:0]});
    modelWrite({c[7:4], d[63:32]});
  endtask

  task automatic doStop();
    @(negedge clk); stopReq = 1;
    @(negedge clk); stopReq = 0;
  endtask

  task automatic doRestart();
    @(negedge clk); restartReq = 1;
    @(negedge clk); restartReq = 0;
  endtask

  task automatic readWord(int a, output logic v, output logic [35:0] d);
    @(negedge clk); hostRdEn = 1; hostAddr = 6'(a);
    @(negedge clk); hostRdEn = 0;
    v = hostRdValid; d = hostRdData;
  endtask

  task automatic readCheck(int a, string tag);
    logic v; logic [35:0] d;
    readWord(a, v, d);
    check({tag, " valid"}, 36'(v), 36'd1);
    check(tag, d, expMem[a]);
  endtask

  task automatic t_reset();
    @(negedge clk);
    check("R1 frozen", 36'(frozen), 0);
    check("R1 rdValid", 36'(hostRdValid), 0);
    check("R1 frzPtr", 36'(frzPtr), 0);
    check("R1 frzWrap", 36'(frzWrap), 0);
  endtask

  task automatic t_basic();
    sendSample(64'h0807060504030201, 8'hA5);
    sendSample(64'hF0E0D0C0B0A09080, 8'h3C);
    sendSample(64'h1122334455667788, 8'h81);
    doStop();
    check("R5 frozen after idle stop", 36'(frozen), 1);
    check("R7 frzPtr", 36'(frzPtr), 36'(expPtr));
    check("R7 frzWrap", 36'(frzWrap), 0);
    for (int a = 0; a < 6; a++) readCheck(a, "R2 word layout");
  endtask

  task automatic t_read_blocked_restart();
    logic v; logic [35:0] d;
    doRestart();
    expPtr = 0; expWrap = 0;
    check("R9 frozen cleared", 36'(frozen), 0);
    check("R9 snapshot cleared", 36'(frzPtr), 0);
    readWord(1, v, d);
    check("R8 read ignored while capturing", 36'(v), 0);
  endtask

  task automatic t_ignored();
    logic [63:0] a = 64'hDEADBEEFCAFEF00D;
    @(negedge clk); sampleValid = 1; chData = a; chCtl = 8'h5A;
    @(negedge clk); chData = 64'h0123456789ABCDEF; chCtl = 8'hFF;
    @(negedge clk); sampleValid = 0;
    modelWrite({4'hA, a[31:0]});
    modelWrite({4'h5, a[63:32]});
    doStop();
    check("R3 ptr advanced by one pair", 36'(frzPtr), 36'(expPtr));
    readCheck(0, "R3 even word keeps first sample");
    readCheck(1, "R3 odd word keeps first sample");
  endtask

  task automatic t_collide();
    logic [63:0] d = 64'h7766554433221100;
    doRestart();
    expPtr = 0; expWrap = 0;
    sendSample(64'h1, 8'h1);
    @(negedge clk); sampleValid = 1; stopReq = 1; chData = d; chCtl = 8'hC3;
    @(negedge clk); sampleValid = 0; stopReq = 0;
    modelWrite({4'h3, d[31:0]});
    modelWrite({4'hC, d[63:32]});
    check("R6 not frozen mid pair", 36'(frozen), 0);
    @(negedge clk);
    check("R6 frozen after odd write", 36'(frozen), 1);
    check("R6 frzPtr", 36'(frzPtr), 36'(expPtr));
    readCheck(2, "R6 even word");
    readCheck(3, "R6 odd word");
  endtask

  task automatic t_restart_capturing();
    doRestart();
    expPtr = 0; expWrap = 0;
    sendSample(64'hAAAA, 8'h0F);
    doRestart();
    sendSample(64'hBBBB, 8'hF0);
    doStop();
    check("R9 restart while capturing ignored", 36'(frzPtr), 36'(expPtr));
  endtask

  task automatic t_wrap();
    doRestart();
    expPtr = 0; expWrap = 0;
    for (int i = 0; i < 33; i++)
      sendSample({32'(i * 7 + 3), 32'(i * 13 + 1)}, 8'(i * 37));
    doStop();
    check("R4 frzPtr after wrap", 36'(frzPtr), 36'(expPtr));
    check("R4 frzWrap", 36'(frzWrap), 36'(expWrap));
    for (int a = 0; a < 64; a++) readCheck(a, "R4 ring content");
  endtask

  task automatic t_frozen_ignores();
    logic [5:0] snap = frzPtr;
    @(negedge clk); sampleValid = 1; chData = '1; chCtl = '1;
    @(negedge clk); @(negedge clk); sampleValid = 0;
    doStop();
    check("R7 snapshot held while frozen", 36'(frzPtr), 36'(snap));
    readCheck(expPtr, "R7 memory untouched while frozen");
    readCheck(expPtr + 1, "R7 memory untouched while frozen");
  endtask

  initial begin
    rstN = 0; sampleValid = 0; chData = '0; chCtl = '0;
    stopReq = 0; restartReq = 0; hostRdEn = 0; hostAddr = '0;
    expPtr = 0; expWrap = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    t_reset();
    t_basic();
    t_read_blocked_restart();
    t_ignored();
    t_collide();
    t_restart_capturing();
    t_wrap();
    t_frozen_ignores();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

endmodule